// File: doc/BRIEF.md
# Prescaled UART Baud Tick Generator

This block turns a free-running reference clock into the oversampling enable that paces a UART transmitter and receiver. The reference is first passed through a prescaler. That prescaler either lets every reference cycle through or keeps only one cycle in four. A 16-bit down-counter then divides the prescaled rate by a programmable divisor. Each time that counter expires, the block asserts `sample_tick` for one reference cycle. It is an enable in the reference clock domain, not a derived clock.

A second output, `bit_tick`, marks one bit period. It is raised together with every 16th sample tick when `osr16_sel` is 1, and with every 8th sample tick when `osr16_sel` is 0. For a given divisor, the 8x mode therefore gives twice the bit rate. The relation is bit rate = f_ref / (prescale × divisor × oversampling). For example, with a 14.7456 MHz reference, 16x oversampling and no prescaling, a divisor of 1 gives 921.6 kbit/s. With prescale 4, a divisor of 24 gives 9600 bit/s.

A small byte-wide write port loads the divisor low byte, the divisor high byte and the prescaler select. The generator stays quiet until a non-zero divisor has been programmed.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high `rst` clears both divisor bytes and the prescaler select. While reset is held and afterwards, `sample_tick` and `bit_tick` stay low until R2 releases them.
- R2: The block is idle until a write to address 0 or 1 leaves the 16-bit divisor non-zero. Writes that leave it zero keep both ticks low. Once armed, the block stays running until reset.
- R3: When bit 7 of the mode register (address 2) is 0, the prescaler passes every reference cycle. `sample_tick` is then a one-cycle pulse every D reference cycles, where D is the divisor.
- R4: When bit 7 of the mode register is 1, the prescaler divides by four, and `sample_tick` pulses every 4·D reference cycles.
- R5: Once armed, a divisor value of 0 acts as 65536, so ticks never stop.
- R6: With `osr16_sel` = 1, `bit_tick` is high together with every 16th `sample_tick` and is never high without `sample_tick`.
- R7: With `osr16_sel` = 0, `bit_tick` is high together with every 8th `sample_tick`. This doubles the bit rate for the same divisor.
- R8: A write to address 0, 1 or 2 restarts the prescaler, the divisor counter and the sample phase. If the write takes effect at clock edge E and the sample period is P, the first `sample_tick` is seen P cycles after E. The first `bit_tick` comes with the 16th (or 8th) sample tick after E.
- R9: A change of `osr16_sel` clears the sample phase at the next clock edge. A sample tick in the cycle where the change is seen is not counted. The next `bit_tick` comes with the 16th (or 8th) sample tick after that edge.
- R10: The register map is: address 0 = divisor bits 7:0, address 1 = divisor bits 15:8, address 2 bit 7 = prescaler select, with the other bits of address 2 ignored. A write to address 3 has no effect and does not restart the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| osr16_sel | input | 1 | 1 selects 16x oversampling, 0 selects 8x |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-period enable, coincident with a sample tick |

## Verification
Two situations are hard to reach from the ports. The first is the divisor-zero case, which only counts as 65536 after the block has been armed by a non-zero write. The bench arms the block first and then writes zeros into both bytes, then waits the full 65536 cycles for the first tick. The second is a switch of oversampling mode while the phase counter is mid-way through a bit. The bench waits for an observed sample tick, flips `osr16_sel` right after it, and expects the first bit tick exactly 8 or 16 sample periods later. Random divisors, prescaler settings and modes are compared cycle by cycle against an expected tick pattern computed from the period formula.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int DIV_W      = 16;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int PRE_FACTOR = 4;
    localparam int OSR_HI     = 16;
    localparam int OSR_LO     = 8;
    localparam int PH_W       = $clog2(OSR_HI);
    localparam int PRESEL_BIT = 7;

    localparam logic [ADDR_W-1:0] REG_DIV_LO = 2'd0;
    localparam logic [ADDR_W-1:0] REG_DIV_HI = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MODE   = 2'd2;

    typedef enum logic {
        OSR_X8  = 1'b0,
        OSR_X16 = 1'b1
    } osr_e;

    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        logic             pre_div4;
    } bcfg_t;

    // Counter reload value: divisor 0 wraps to all ones, i.e. 65536 counts.
    function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
        return d - 1'b1;
    endfunction

    function automatic logic [PH_W-1:0] phase_last(input osr_e m);
        return (m == OSR_X16) ? PH_W'(OSR_HI - 1) : PH_W'(OSR_LO - 1);
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bcfg_t             cfg_q,
    output bcfg_t             cfg_d,
    output logic              restart,
    output logic              armed
);

    logic div_wr;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                REG_DIV_LO: cfg_d.divisor[0 +: DATA_W]      = wdata;
                REG_DIV_HI: cfg_d.divisor[DATA_W +: DATA_W] = wdata;
                REG_MODE:   cfg_d.pre_div4                  = wdata[PRESEL_BIT];
                default:    ;
            endcase
        end
    end

    assign div_wr  = we && ((addr == REG_DIV_LO) || (addr == REG_DIV_HI));
    assign restart = div_wr || (we && (addr == REG_MODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            armed <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            if (div_wr && (cfg_d.divisor != '0))
                armed <= 1'b1;
        end
    end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baudgen_pkg::*;
#(
    parameter int FACTOR = PRE_FACTOR
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic div_en,
    output logic pre_tick
);

    localparam int CW = (FACTOR > 1) ? $clog2(FACTOR) : 1;
    localparam logic [CW-1:0] LAST = CW'(FACTOR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= LAST;
        else if (div_en)
            cnt <= (cnt == '0) ? LAST : cnt - 1'b1;
    end

    assign pre_tick = run && (!div_en || (cnt == '0));

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] cur_div,
    input  logic [DIV_W-1:0] load_div,
    output logic             sample_tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= reload_of('0);
        else if (!run || restart)
            cnt <= reload_of(load_div);
        else if (pre_tick)
            cnt <= (cnt == '0) ? reload_of(cur_div) : cnt - 1'b1;
    end

    assign sample_tick = run && pre_tick && (cnt == '0);

endmodule

// File: rtl/baud_phase.sv
module baud_phase
    import baudgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic            osr16_sel,
    input  logic            sample_tick,
    output logic            bit_tick,
    output logic [PH_W-1:0] phase,
    output osr_e            mode_q
);

    osr_e            mode_now;
    logic            mode_chg;
    logic [PH_W-1:0] last;

    assign mode_now = osr_e'(osr16_sel);
    assign mode_chg = (mode_now != mode_q);
    assign last     = phase_last(mode_q);

    always_ff @(posedge clk) begin
        mode_q <= mode_now;
        if (rst || !run || restart || mode_chg)
            phase <= '0;
        else if (sample_tick)
            phase <= (phase == last) ? '0 : phase + 1'b1;
    end

    assign bit_tick = sample_tick && !mode_chg && (phase == last);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              osr16_sel,
    output logic              sample_tick,
    output logic              bit_tick
);

    bcfg_t           cfg_q;
    bcfg_t           cfg_d;
    logic            restart;
    logic            armed;
    logic            pre_tick;
    logic [PH_W-1:0] phase;
    osr_e            mode_q;

    baud_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .restart (restart),
        .armed   (armed)
    );

    baud_prescaler #(.FACTOR(PRE_FACTOR)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (armed),
        .restart  (restart),
        .div_en   (cfg_q.pre_div4),
        .pre_tick (pre_tick)
    );

    baud_divider u_div (
        .clk         (clk),
        .rst         (rst),
        .run         (armed),
        .restart     (restart),
        .pre_tick    (pre_tick),
        .cur_div     (cfg_q.divisor),
        .load_div    (cfg_d.divisor),
        .sample_tick (sample_tick)
    );

    baud_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .run         (armed),
        .restart     (restart),
        .osr16_sel   (osr16_sel),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick),
        .phase       (phase),
        .mode_q      (mode_q)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baudgen_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sample_tick,
    input logic            bit_tick,
    input logic            armed,
    input logic            pre_div4,
    input logic            osr16_sel,
    input osr_e            mode_q,
    input logic [PH_W-1:0] phase
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sample_tick && !bit_tick);

    a_r2_idle_until_armed: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !sample_tick && !bit_tick);

    a_r4_div4_spacing: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && pre_div4) |-> !$past(sample_tick));

    a_r6_bit_with_sample: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    a_r7_phase_range_x8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OSR_X8) |-> (phase < PH_W'(OSR_LO)));

    a_r9_mode_change_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(osr16_sel) != $past(mode_q)) |-> (phase == '0));

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .armed       (armed),
    .pre_div4    (cfg_q.pre_div4),
    .osr16_sel   (osr16_sel),
    .mode_q      (mode_q),
    .phase       (phase)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       osr16 = 1'b1;
    logic       st;
    logic       bt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (we),
        .cfg_addr    (addr),
        .cfg_wdata   (wdata),
        .osr16_sel   (osr16),
        .sample_tick (st),
        .bit_tick    (bt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge right after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic program_div(input int d, input bit div4);
        wr(2'd2, div4 ? 8'h80 : 8'h3F);
        wr(2'd1, 8'((d >> 8) & 8'hFF));
        wr(2'd0, 8'(d & 8'hFF));
    endtask

    task automatic idle(input int n, input string req);
        int seen = 0;
        for (int c = 0; c < n; c++) begin
            if (st !== 1'b0 || bt !== 1'b0) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, "tick cycles while idle", seen, 0);
    endtask

    // Cycle c = 0 is the first negedge after the restarting edge.
    function automatic bit exp_sample(input int c, input int p);
        return ((c + 1) % p) == 0;
    endfunction

    function automatic bit exp_bit(input int c, input int p, input int osr);
        return exp_sample(c, p) && ((((c + 1) / p) % osr) == 0);
    endfunction

    task automatic measure(input int p, input int osr, input int ncyc,
                           input int start, input string req);
        int bad_s = 0, bad_b = 0, fs = -1, fb = -1, ns = 0, nb = 0;
        for (int c = start; c < ncyc; c++) begin
            if (st !== exp_sample(c, p)) begin if (fs < 0) fs = c; bad_s++; end
            if (bt !== exp_bit(c, p, osr)) begin if (fb < 0) fb = c; bad_b++; end
            if (st === 1'b1) ns++;
            if (bt === 1'b1) nb++;
            @(negedge clk);
        end
        chk(bad_s == 0, req, $sformatf("sample pattern P=%0d first bad cycle %0d, ticks seen", p, fs),
            ns, (ncyc / p) - (start / p));
        chk(bad_b == 0, req, $sformatf("bit pattern osr=%0d first bad cycle %0d, bits seen", osr, fb),
            nb, ncyc / (p * osr));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        idle(1, "R1");                 // held in reset: no ticks
        rst = 1'b0;
        idle(50, "R1");

        // R2: zero divisor writes keep the block idle
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h80);
        idle(100, "R2");

        // R3: divisor 1, no prescale, every cycle
        osr16 = 1'b1;
        program_div(1, 1'b0);
        measure(1, 16, 64, 0, "R3");

        // R10: address 3 write has no effect and no restart
        program_div(4, 1'b0);
        wr(2'd3, 8'hFF);
        measure(4, 16, 4 * 16 * 2, 1, "R10");

        // R4 + R6: prescale 4, divisor 24 -> 96 cycles
        program_div(24, 1'b1);
        measure(96, 16, 96 * 16 * 2, 0, "R4");

        // R7: 8x mode, divisor 2 with prescale 4
        osr16 = 1'b0;
        program_div(2, 1'b1);
        measure(8, 8, 8 * 8 * 3, 0, "R7");

        // R10: high byte position, divisor 0x0102
        program_div(16'h0102, 1'b0);
        measure(258, 8, 258 * 8 * 2, 0, "R10");

        // R8: restart mid-stream via divisor rewrite, then via mode register
        osr16 = 1'b1;
        program_div(5, 1'b0);
        measure(5, 16, 37, 0, "R8");
        wr(2'd0, 8'd5);
        measure(5, 16, 5 * 16 * 2, 0, "R8");
        wr(2'd2, 8'h80);
        measure(20, 16, 20 * 16 * 2, 0, "R8");

        // R9: switch oversampling right after an observed sample tick
        program_div(3, 1'b0);
        measure(3, 16, 20, 0, "R9");
        while (st !== 1'b1) @(negedge clk);
        osr16 = 1'b0;
        @(negedge clk);
        measure(3, 8, 3 * 8 * 2, 0, "R9");
        while (st !== 1'b1) @(negedge clk);
        osr16 = 1'b1;
        @(negedge clk);
        measure(3, 16, 3 * 16 * 2, 0, "R9");

        // Random mix of divisor, prescaler and mode (R3/R4/R6/R7)
        for (int i = 0; i < 8; i++) begin
            int d   = int'($urandom_range(20, 1));
            bit p4  = 1'($urandom_range(1, 0));
            bit o16 = 1'($urandom_range(1, 0));
            int per = d * (p4 ? 4 : 1);
            int osr = o16 ? 16 : 8;
            osr16 = o16;
            program_div(d, p4);
            measure(per, osr, per * osr * 2, 0, "R3/R4/R6/R7");
        end

        // R5: divisor 0 after arming counts 65536
        osr16 = 1'b1;
        program_div(0, 1'b0);
        measure(65536, 16, 65540, 0, "R5");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule